// File: doc/BRIEF.md
# Receiver Port Status Register

This block keeps the 8-bit status word for one serial receiver port and returns it through a register bus read strobe. Some bits in the word are live levels: the lock state, the pass indication and a parity-overflow compare. The other bits are sticky event flags. They latch control-channel CRC errors, control-channel sequence errors and changes in the lock state. They stay set until a read clears them, so an event is not missed between two polls.

A read is captured into a holding register on the cycle after the strobe. The captured value is the word as it stood before the clear, so the reader sees the events that caused the flags. A mode input changes the meaning of one bit. With the mode off, that bit is a sequence-error flag that clears on read. With the mode on, it is a summary of any control-channel error, and only a read of a separate control-channel status register clears it. The block also counts parity error pulses and compares the count against a programmable threshold. A dedicated clear strobe resets that count.

Top module: `rxport_stat_reg`

## Requirements
- R1: Bits 7:6 of the read word carry `port_sel` as sampled with the read strobe.
- R2: Bit 5 sets one cycle after a `crc_err_pulse`. It stays set until a read strobe clears it.
- R3: Bit 4 sets when the synchronized lock level differs from its value one cycle earlier. A read strobe clears it.
- R4: With `enh_err_mode` = 0, bit 3 is a sticky sequence-error flag. It is set by `seq_err_pulse` and cleared by a read strobe.
- R5: With `enh_err_mode` = 1, bit 3 is a summary flag, set by either `crc_err_pulse` or `seq_err_pulse`. A read strobe does not clear it; only `ctl_stat_rd` does.
- R6: Bit 2 is 1 while the count of `par_err_pulse` events is strictly greater than `par_thresh`. The count saturates at its maximum. `par_clr` resets the count to zero and wins over a pulse in the same cycle, so bit 2 is 0 one cycle after `par_clr`.
- R7: Bit 1 is the live pass level, taken after a two-stage synchronizer.
- R8: Bit 0 is the live lock level (1 = locked), taken after a two-stage synchronizer.
- R9: After reset, all flags, all synchronizers and `rd_data` are 0.
- R10: If an event arrives in the same cycle as the strobe that would clear its flag, the flag stays set.
- R11: `rd_data` is loaded only on a read strobe, one cycle after it. It holds the word from before that strobe's clear, and keeps that value until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_in | input | 1 | Receiver lock level, asynchronous |
| pass_in | input | 1 | Receiver pass level, asynchronous |
| crc_err_pulse | input | 1 | One-cycle control-channel CRC error event |
| seq_err_pulse | input | 1 | One-cycle control-channel sequence error event |
| par_err_pulse | input | 1 | One-cycle parity error event |
| par_thresh | input | CNT_W | Parity error threshold |
| par_clr | input | 1 | Parity counter clear strobe |
| enh_err_mode | input | 1 | Selects the summary meaning of bit 3 |
| ctl_stat_rd | input | 1 | Read strobe of the control-channel status register |
| port_sel | input | 2 | Number of the selected receive port |
| rd_stb | input | 1 | Status word read strobe |
| rd_data | output | 8 | Captured status word |

## Verification
On every cycle the assertions check the following:
- each sticky flag sets one cycle after its event;
- a read strobe clears the flags unless an event arrives with it;
- a read strobe leaves the summary flag untouched;
- a parity clear forces the compare low;
- `rd_data` changes only after a strobe, and its port field matches.

Some behaviours only the bench's scenarios can show:
- the mode switch on bit 3;
- the strict boundary of the threshold compare;
- the synchronizer delay of the live bits;
- a read that returns the pre-clear word when it coincides with a new event.

// File: rtl/rxps_pkg.sv
package rxps_pkg;

    localparam int WORD_W    = 8;
    localparam int PORT_W    = 2;
    localparam int NUM_FLAGS = 4;

    // Sticky flag slots
    localparam int FLG_CRC  = 0;
    localparam int FLG_LCHG = 1;
    localparam int FLG_SEQ  = 2;
    localparam int FLG_CTL  = 3;

    typedef enum logic [0:0] {
        CLR_BY_STATUS_RD = 1'b0,
        CLR_BY_CTL_RD    = 1'b1
    } clr_src_e;

    typedef struct packed {
        logic [PORT_W-1:0] port;
        logic              crc;
        logic              lock_chg;
        logic              ctl;
        logic              par_over;
        logic              pass;
        logic              lock;
    } stat_word_t;

    function automatic clr_src_e flag_clr_src(input int idx);
        return (idx == FLG_CTL) ? CLR_BY_CTL_RD : CLR_BY_STATUS_RD;
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(input stat_word_t w);
        return w;
    endfunction

endpackage

// File: rtl/rxps_sync.sv
module rxps_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= async_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/rxps_sticky.sv
module rxps_sticky #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_evt,
    input  logic [N-1:0] clr_req,
    output logic [N-1:0] flag_q
);
    // A set in the same cycle as a clear keeps the flag high
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) flag_q[i] <= 1'b0;
            else     flag_q[i] <= set_evt[i] | (flag_q[i] & ~clr_req[i]);
        end
    end
endmodule

// File: rtl/rxps_parity_mon.sv
module rxps_parity_mon #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             err_pulse,
    input  logic             cnt_clr,
    input  logic [CNT_W-1:0] thresh,
    output logic             over
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                              cnt_q <= '0;
        else if (cnt_clr)                     cnt_q <= '0;
        else if (err_pulse && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end

    assign over = (cnt_q > thresh);
endmodule

// File: rtl/rxport_stat_reg.sv
module rxport_stat_reg
    import rxps_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    lock_in,
    input  logic                    pass_in,
    input  logic                    crc_err_pulse,
    input  logic                    seq_err_pulse,
    input  logic                    par_err_pulse,
    input  logic [CNT_W-1:0]        par_thresh,
    input  logic                    par_clr,
    input  logic                    enh_err_mode,
    input  logic                    ctl_stat_rd,
    input  logic [PORT_W-1:0]       port_sel,
    input  logic                    rd_stb,
    output logic [WORD_W-1:0]       rd_data
);
    logic [1:0]           lvl_s;
    logic                 lock_s, pass_s;
    logic                 lock_prev;
    logic [NUM_FLAGS-1:0] set_evt, clr_req, flag_q;
    logic                 par_over;
    stat_word_t           word;
    logic [WORD_W-1:0]    rd_q;

    rxps_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst),
        .async_in({pass_in, lock_in}),
        .sync_out(lvl_s)
    );
    assign lock_s = lvl_s[0];
    assign pass_s = lvl_s[1];

    always_ff @(posedge clk) begin
        if (rst) lock_prev <= 1'b0;
        else     lock_prev <= lock_s;
    end

    always_comb begin
        set_evt           = '0;
        set_evt[FLG_CRC]  = crc_err_pulse;
        set_evt[FLG_LCHG] = lock_s ^ lock_prev;
        set_evt[FLG_SEQ]  = seq_err_pulse;
        set_evt[FLG_CTL]  = crc_err_pulse | seq_err_pulse;
    end

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_clr
        if (flag_clr_src(i) == CLR_BY_CTL_RD) begin : g_ctl
            assign clr_req[i] = ctl_stat_rd;
        end else begin : g_stat
            assign clr_req[i] = rd_stb;
        end
    end

    rxps_sticky #(.N(NUM_FLAGS)) u_sticky (
        .clk(clk), .rst(rst),
        .set_evt(set_evt), .clr_req(clr_req), .flag_q(flag_q)
    );

    rxps_parity_mon #(.CNT_W(CNT_W)) u_par (
        .clk(clk), .rst(rst),
        .err_pulse(par_err_pulse), .cnt_clr(par_clr),
        .thresh(par_thresh), .over(par_over)
    );

    always_comb begin
        word.port     = port_sel;
        word.crc      = flag_q[FLG_CRC];
        word.lock_chg = flag_q[FLG_LCHG];
        word.ctl      = enh_err_mode ? flag_q[FLG_CTL] : flag_q[FLG_SEQ];
        word.par_over = par_over;
        word.pass     = pass_s;
        word.lock     = lock_s;
    end

    always_ff @(posedge clk) begin
        if (rst)         rd_q <= '0;
        else if (rd_stb) rd_q <= pack_word(word);
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/rxport_stat_reg_chk.sv
module rxport_stat_reg_chk
    import rxps_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 rd_stb,
    input logic                 ctl_stat_rd,
    input logic                 crc_err_pulse,
    input logic                 seq_err_pulse,
    input logic                 par_clr,
    input logic [PORT_W-1:0]    port_sel,
    input logic [WORD_W-1:0]    rd_data,
    input logic [NUM_FLAGS-1:0] flags,
    input logic                 lock_s,
    input logic                 par_over
);
    assert_port_field_R1: assert property (@(posedge clk) disable iff (rst)
        rd_stb |=> rd_data[7:6] == $past(port_sel));

    assert_crc_set_R2: assert property (@(posedge clk) disable iff (rst)
        crc_err_pulse |=> flags[FLG_CRC]);

    assert_crc_clear_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && !crc_err_pulse) |=> !flags[FLG_CRC]);

    assert_lock_chg_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(lock_s) |=> flags[FLG_LCHG]);

    assert_seq_set_R4: assert property (@(posedge clk) disable iff (rst)
        seq_err_pulse |=> flags[FLG_SEQ]);

    assert_ctl_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (flags[FLG_CTL] && !ctl_stat_rd) |=> flags[FLG_CTL]);

    assert_par_clear_R6: assert property (@(posedge clk) disable iff (rst)
        par_clr |=> !par_over);

    assert_coincide_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && seq_err_pulse) |=> flags[FLG_SEQ]);

    assert_rd_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> $stable(rd_data));
endmodule

bind rxport_stat_reg rxport_stat_reg_chk chk_i (
    .clk(clk), .rst(rst), .rd_stb(rd_stb), .ctl_stat_rd(ctl_stat_rd),
    .crc_err_pulse(crc_err_pulse), .seq_err_pulse(seq_err_pulse),
    .par_clr(par_clr), .port_sel(port_sel), .rd_data(rd_data),
    .flags(flag_q), .lock_s(lock_s), .par_over(par_over)
);

// File: tb/rxport_stat_reg_tb_top.sv
module rxport_stat_reg_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lock_in = 0, pass_in = 0, crc_err_pulse = 0, seq_err_pulse = 0;
    logic par_err_pulse = 0, par_clr = 0, enh_err_mode = 0, ctl_stat_rd = 0, rd_stb = 0;
    logic [CW-1:0] par_thresh = 8'd3;
    logic [1:0] port_sel = 2'b00;
    logic [7:0] rd_data;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    typedef struct { logic [7:0] exp; string tag; } item_t;
    item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rxport_stat_reg #(.CNT_W(CW), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst), .lock_in(lock_in), .pass_in(pass_in),
        .crc_err_pulse(crc_err_pulse), .seq_err_pulse(seq_err_pulse),
        .par_err_pulse(par_err_pulse), .par_thresh(par_thresh), .par_clr(par_clr),
        .enh_err_mode(enh_err_mode), .ctl_stat_rd(ctl_stat_rd),
        .port_sel(port_sel), .rd_stb(rd_stb), .rd_data(rd_data)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: rd_data=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: one read strobe, expected word pushed to the scoreboard
    task automatic do_read(input logic [7:0] exp, input string tag);
        item_t it;
        it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse(ref logic sig);
        sig = 1'b1;
        @(negedge clk);
        sig = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: compare the word that appears after each strobe
    initial begin
        forever begin
            @(posedge clk);
            if (rd_stb) begin
                @(negedge clk);
                if (sb_q.size() == 0) begin
                    n_checks++; n_fail++;
                    $display("FAIL R11: unexpected read, rd_data=%02h expected=none", rd_data);
                end else begin
                    item_t it;
                    it = sb_q.pop_front();
                    check(rd_data, it.exp, it.tag);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        check(rd_data, 8'h00, "R9 reset value");
        do_read(8'h00, "R9 first read after reset");

        port_sel = 2'b10;
        do_read(8'h80, "R1 port field");

        pulse(crc_err_pulse);
        do_read(8'hA0, "R2 crc flag set");
        do_read(8'h80, "R2 crc flag cleared by read");

        lock_in = 1'b1; idle(5);
        do_read(8'h91, "R3 R8 lock rise and change flag");
        do_read(8'h81, "R3 change flag cleared, R8 lock live");

        pass_in = 1'b1; idle(5);
        do_read(8'h83, "R7 pass high");
        pass_in = 1'b0; idle(5);
        do_read(8'h81, "R7 pass low");

        pulse(seq_err_pulse);
        do_read(8'h89, "R4 seq flag set");
        do_read(8'h81, "R4 seq flag cleared");

        // Summary flag still holds the earlier crc and seq events
        enh_err_mode = 1'b1; idle(1);
        do_read(8'h89, "R5 summary flag visible");
        do_read(8'h89, "R5 summary flag not cleared by read");
        pulse(ctl_stat_rd);
        do_read(8'h81, "R5 summary cleared by ctl read");
        pulse(crc_err_pulse);
        do_read(8'hA9, "R5 crc sets summary");
        do_read(8'h89, "R5 summary survives crc clear");
        pulse(ctl_stat_rd);
        do_read(8'h81, "R5 summary cleared again");
        enh_err_mode = 1'b0; idle(1);
        do_read(8'h81, "R4 seq flag cleared by earlier reads");

        repeat (3) pulse(par_err_pulse);
        do_read(8'h81, "R6 count equal threshold not over");
        pulse(par_err_pulse);
        do_read(8'h85, "R6 count above threshold");
        do_read(8'h85, "R6 over bit is live, not cleared by read");
        par_clr = 1'b1; par_err_pulse = 1'b1;
        @(negedge clk);
        par_clr = 1'b0; par_err_pulse = 1'b0;
        par_thresh = 8'd0; idle(1);
        do_read(8'h81, "R6 clear wins over pulse");

        // Event and clearing read in the same cycle
        crc_err_pulse = 1'b1; seq_err_pulse = 1'b1;
        do_read_coincide();
        do_read(8'hA9, "R10 flags kept after coincident read");
        do_read(8'h81, "R10 flags cleared by later read");

        lock_in = 1'b0; idle(5);
        do_read(8'h90, "R3 lock fall sets change flag");
        pulse(crc_err_pulse);
        idle(3);
        check(rd_data, 8'h90, "R11 rd_data holds without strobe");

        idle(3);
        if (sb_q.size() != 0) begin
            n_checks++; n_fail++;
            $display("FAIL R11: %0d reads not seen, expected 0", sb_q.size());
        end
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    task automatic do_read_coincide();
        item_t it;
        it.exp = 8'h81; it.tag = "R11 R10 coincident read shows pre-clear word";
        sb_q.push_back(it);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0; crc_err_pulse = 1'b0; seq_err_pulse = 1'b0;
        @(negedge clk);
    endtask
endmodule